// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the 32 already-synchronized inputs of one GPIO bank, split into four ports of eight pins, and turns selected activity on them into a single bank interrupt. Each pin can be set to one of five trigger kinds: rising edge, falling edge, either edge, active-high level or active-low level. A detected event lands in a per-pin status bit. A per-pin enable decides whether that status bit reaches the bank interrupt line.

Software reaches the block through a simple synchronous write port and a combinational read port. Each port has a status register, an enable register, a type register and a write-one-to-clear register. There are also masked aliases of status, enable and type. In a masked write, a mask byte selects which pins the value touches, so one pin can be reprogrammed without a read-modify-write.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is applied, every status, enable and type register reads 0 and `irq_o` is 0.
- R2: The type register holds three planes: bits [7:0] are polarity-high, bits [15:8] are edge-select and bits [23:16] are any-edge, with bit n of each plane belonging to pin n. With edge and high set (rising), a 0-to-1 change on a pin sets its status bit on the next clock. A 1-to-0 change does not.
- R3: With only edge set (falling), a 1-to-0 change sets the status bit. A 0-to-1 change does not.
- R4: With edge and any-edge set, either change sets the status bit.
- R5: With edge clear, the pin is level type. With high set, status follows the pin being 1; with all three planes clear, status follows the pin being 0. A clear drops the bit for one cycle, and it is set again on the following cycle if the level is still active.
- R6: Writing to the clear register (offset 0x70) clears the status bits whose write bits are 1 and leaves the rest unchanged. An edge-type status bit stays set until it is cleared. An edge that arrives in the same cycle as its clear leaves the bit set.
- R7: `irq_o` is 1 exactly when some pin in the bank has both its status bit and its enable bit (offset 0x50) set. Clearing an enable bit removes the pin from `irq_o` but keeps its status.
- R8: A masked enable write (offset 0xD0) changes only the enable bits selected by wdata[15:8], loading them from wdata[7:0]. A masked type write (offset 0xE0) changes only the pins selected by wdata[31:24], loading all three planes for those pins from wdata[23:0].
- R9: A masked status write (offset 0xC0) forces the selected status bits (mask wdata[15:8]) to the values in wdata[7:0].
- R10: A pin's edge detection is suppressed in the cycle its type is written and in the following cycle, so history from before the type change never produces an event.
- R11: Register address = offset + 4 × port, with the port index in addr[3:2]. Plain registers are at 0x40 (status), 0x50 (enable), 0x60 (type) and 0x70 (clear). A write to one port changes no other port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 32 | Synchronized pin levels, pin 8×port+n |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Bank interrupt |

## Verification
A wrong trigger decode or stale edge history appears one clock after the pin change, as an extra or missing status bit in the port's status read. A wrong clear or masked-write merge shows up in the status or enable byte right after the write edge. For level types the erroneous value must be gone one cycle later, because status is recomputed from the pin. A fault in the interrupt merge is visible on `irq_o` in the same cycle as the enable or status change that exposes it, so each enable change is followed by an immediate check of the line.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int PINS = 8;

  localparam int OFS_STAT = 32'h40;
  localparam int OFS_EN   = 32'h50;
  localparam int OFS_TYPE = 32'h60;
  localparam int OFS_CLR  = 32'h70;

  typedef struct packed {
    logic [PINS-1:0] bo;
    logic [PINS-1:0] eg;
    logic [PINS-1:0] hi;
  } gid_type_t;

  typedef struct packed {
    logic en_wr;
    logic en_mwr;
    logic ty_wr;
    logic ty_mwr;
    logic st_mwr;
    logic clr_wr;
  } port_cmd_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STAT,
    RD_EN,
    RD_TYPE
  } rd_sel_t;
endpackage

// File: rtl/gid_decode.sv
module gid_decode
  import gid_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NPORTS    = 4,
  parameter int UPPER_OFS = 32'h80,
  localparam int PIDX_W   = $clog2(NPORTS)
) (
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  output port_cmd_t [NPORTS-1:0] cmd,
  output rd_sel_t                rd_sel,
  output logic [PIDX_W-1:0]      rd_port
);
  logic [ADDR_W-1:0] regoff;
  logic is_st, is_en, is_ty, is_clr, is_mst, is_men, is_mty;

  always_comb begin
    regoff  = {addr[ADDR_W-1:PIDX_W+2], {(PIDX_W+2){1'b0}}};
    rd_port = addr[PIDX_W+1:2];
    is_st   = (regoff == ADDR_W'(OFS_STAT));
    is_en   = (regoff == ADDR_W'(OFS_EN));
    is_ty   = (regoff == ADDR_W'(OFS_TYPE));
    is_clr  = (regoff == ADDR_W'(OFS_CLR));
    is_mst  = (regoff == ADDR_W'(UPPER_OFS + OFS_STAT));
    is_men  = (regoff == ADDR_W'(UPPER_OFS + OFS_EN));
    is_mty  = (regoff == ADDR_W'(UPPER_OFS + OFS_TYPE));
    if (is_st || is_mst)      rd_sel = RD_STAT;
    else if (is_en || is_men) rd_sel = RD_EN;
    else if (is_ty || is_mty) rd_sel = RD_TYPE;
    else                      rd_sel = RD_NONE;
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_cmd
    logic hit;
    assign hit           = we && (rd_port == PIDX_W'(g));
    assign cmd[g].en_wr  = hit && is_en;
    assign cmd[g].en_mwr = hit && is_men;
    assign cmd[g].ty_wr  = hit && is_ty;
    assign cmd[g].ty_mwr = hit && is_mty;
    assign cmd[g].st_mwr = hit && is_mst;
    assign cmd[g].clr_wr = hit && is_clr;
  end
endmodule

// File: rtl/gid_port.sv
module gid_port
  import gid_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  input  port_cmd_t       cmd,
  input  logic [31:0]     wdata,
  output logic [PINS-1:0] st_o,
  output logic [PINS-1:0] en_o,
  output gid_type_t       ty_o,
  output logic [PINS-1:0] ev_o,
  output logic [PINS-1:0] clr_o,
  output logic [PINS-1:0] eg_o,
  output logic [PINS-1:0] sset_o,
  output logic [PINS-1:0] tyw_o
);
  logic [PINS-1:0] st_q, st_d, en_q, en_d, prev_q, hist_q, hist_d;
  gid_type_t       ty_q, ty_d, wtype;
  logic [PINS-1:0] ty_msk, en_msk, s_msk, rise, fall, hit, ev, lvl, clr, base, sset;

  // next-state
  always_comb begin
    wtype  = gid_type_t'(wdata[3*PINS-1:0]);
    ty_msk = cmd.ty_wr ? '1 : (cmd.ty_mwr ? wdata[31:24] : '0);
    ty_d.hi = (ty_q.hi & ~ty_msk) | (wtype.hi & ty_msk);
    ty_d.eg = (ty_q.eg & ~ty_msk) | (wtype.eg & ty_msk);
    ty_d.bo = (ty_q.bo & ~ty_msk) | (wtype.bo & ty_msk);

    en_msk = cmd.en_wr ? '1 : (cmd.en_mwr ? wdata[15:8] : '0);
    en_d   = (en_q & ~en_msk) | (wdata[PINS-1:0] & en_msk);

    rise = pin_i & ~prev_q;
    fall = ~pin_i & prev_q;
    hit  = (ty_q.bo & (rise | fall))
         | (~ty_q.bo & ty_q.hi & rise)
         | (~ty_q.bo & ~ty_q.hi & fall);
    ev   = ty_q.eg & hist_q & ~ty_msk & hit;
    lvl  = ~ty_q.eg & ~(pin_i ^ ty_q.hi);

    clr  = cmd.clr_wr ? wdata[PINS-1:0] : '0;
    base = ((ty_q.eg & st_q) | lvl) & ~clr;
    s_msk = cmd.st_mwr ? wdata[15:8] : '0;
    sset  = s_msk & wdata[PINS-1:0];
    st_d  = (base & ~s_msk) | sset | ev;

    hist_d = ~ty_msk;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      en_q   <= '0;
      ty_q   <= '0;
      prev_q <= '0;
      hist_q <= '0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_d;
      ty_q   <= ty_d;
      prev_q <= pin_i;
      hist_q <= hist_d;
    end
  end

  assign st_o   = st_q;
  assign en_o   = en_q;
  assign ty_o   = ty_q;
  assign ev_o   = ev;
  assign clr_o  = clr;
  assign eg_o   = ty_q.eg;
  assign sset_o = sset;
  assign tyw_o  = ty_msk;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gid_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 32'h80,
  localparam int NPINS    = NPORTS * PINS,
  localparam int PIDX_W   = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  logic [1:0] rs_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  port_cmd_t [NPORTS-1:0] cmd;
  rd_sel_t                rd_sel;
  logic [PIDX_W-1:0]      rd_port;

  gid_decode #(.ADDR_W(ADDR_W), .NPORTS(NPORTS), .UPPER_OFS(UPPER_OFS)) u_dec (
    .we(bus_we), .addr(bus_addr), .cmd(cmd), .rd_sel(rd_sel), .rd_port(rd_port)
  );

  logic [PINS-1:0] st_arr [NPORTS];
  logic [PINS-1:0] en_arr [NPORTS];
  gid_type_t       ty_arr [NPORTS];
  logic [NPINS-1:0] st_all, en_all, ev_all, clr_all, edge_all, sset_all, tyw_all;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    gid_port u_port (
      .clk(clk), .rst_n(rst_q),
      .pin_i(pin_i[g*PINS +: PINS]), .cmd(cmd[g]), .wdata(bus_wdata),
      .st_o(st_arr[g]), .en_o(en_arr[g]), .ty_o(ty_arr[g]),
      .ev_o(ev_all[g*PINS +: PINS]), .clr_o(clr_all[g*PINS +: PINS]),
      .eg_o(edge_all[g*PINS +: PINS]), .sset_o(sset_all[g*PINS +: PINS]),
      .tyw_o(tyw_all[g*PINS +: PINS])
    );
    assign st_all[g*PINS +: PINS] = st_arr[g];
    assign en_all[g*PINS +: PINS] = en_arr[g];
  end

  assign irq_o = |(st_all & en_all);

  always_comb begin
    bus_rdata = '0;
    case (rd_sel)
      RD_STAT: bus_rdata[PINS-1:0]   = st_arr[rd_port];
      RD_EN:   bus_rdata[PINS-1:0]   = en_arr[rd_port];
      RD_TYPE: bus_rdata[3*PINS-1:0] = ty_arr[rd_port];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_q,
  input logic             irq_o,
  input logic [NPINS-1:0] st_all,
  input logic [NPINS-1:0] ev_all,
  input logic [NPINS-1:0] clr_all,
  input logic [NPINS-1:0] edge_all,
  input logic [NPINS-1:0] sset_all,
  input logic [NPINS-1:0] tyw_all
);
  // R1: no interrupt and no status while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_q |-> (!irq_o && st_all == '0));

  // R6: a detected edge is always captured
  p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (($past(ev_all) & ~st_all) == '0));

  // R6: a clear with no competing event leaves an edge-type bit at 0
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> ((st_all & $past(clr_all & edge_all & ~ev_all & ~sset_all)) == '0));

  // R2: an edge-type status bit only rises through an event or a forced set
  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> ((st_all & ~$past(st_all) & $past(edge_all) & ~$past(ev_all | sset_all)) == '0));

  // R10: no event in the cycle of a type write or the one after
  p_type_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |-> ((ev_all & (tyw_all | $past(tyw_all))) == '0));

  // R7: interrupt needs some pending status
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_q)
    irq_o |-> (st_all != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_q(rst_q), .irq_o(irq_o), .st_all(st_all), .ev_all(ev_all),
  .clr_all(clr_all), .edge_all(edge_all), .sset_all(sset_all), .tyw_all(tyw_all)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pins;
  logic        we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  function automatic logic [11:0] ra(input int ofs, input int p);
    return 12'(ofs + 4 * p);
  endfunction

  // 0 rising, 1 falling, 2 both, 3 level high, 4 level low
  function automatic logic [31:0] tword(input int t);
    logic hi, eg, bo;
    hi = (t == 0) || (t == 3);
    eg = (t < 3);
    bo = (t == 2);
    return {8'h00, {8{bo}}, {8{eg}}, {8{hi}}};
  endfunction

  function automatic string tname(input int t);
    case (t)
      0: return "R2 rising";
      1: return "R3 falling";
      2: return "R4 both";
      3: return "R5 level-high";
      default: return "R5 level-low";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins = '1; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) tick();
    for (int p = 0; p < 4; p++) begin
      chk_rd(ra('h40, p), 32'h0, "R1 status in reset");
      chk_rd(ra('h50, p), 32'h0, "R1 enable in reset");
      chk_rd(ra('h60, p), 32'h0, "R1 type in reset");
    end
    chk_irq(1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    repeat (4) tick();

    // R11: per-port enable registers are distinct
    for (int p = 0; p < 4; p++) wr(ra('h50, p), 32'(8'h11 << p));
    for (int p = 0; p < 4; p++) chk_rd(ra('h50, p), 32'(8'h11 << p), "R11 port decode");
    for (int p = 0; p < 4; p++) wr(ra('h50, p), 32'h0);

    // sweep all types over all pins
    for (int t = 0; t < 5; t++) begin
      logic [7:0] oth;
      logic ised, fs, rs, lh;
      ised = (t < 3); fs = (t == 1) || (t == 2); rs = (t == 0) || (t == 2); lh = (t == 3);
      oth  = lh ? 8'hFF : 8'h00;
      for (int p = 0; p < 4; p++) wr(ra('h60, p), tword(t));
      for (int p = 0; p < 4; p++) begin
        chk_rd(ra('h60, p), tword(t), "R2 type planes readback");
        for (int n = 0; n < 8; n++) begin
          logic [7:0] e;
          wr(ra('h70, p), 32'hFF);
          chk_rd(ra('h40, p), 32'h0, {tname(t), " R6 after clear"});
          tick();
          chk_rd(ra('h40, p), {24'h0, oth}, {tname(t), " R5 reassert"});
          pins[p*8+n] = 1'b0;
          tick();
          e = oth; e[n] = ised ? fs : (t == 4);
          chk_rd(ra('h40, p), {24'h0, e}, {tname(t), " pin low"});
          wr(ra('h70, p), 32'hFF);
          pins[p*8+n] = 1'b1;
          tick();
          e = oth; e[n] = ised ? rs : lh;
          chk_rd(ra('h40, p), {24'h0, e}, {tname(t), " pin high"});
        end
      end
    end

    // R7: enable masks without losing status
    wr(ra('h60, 1), 32'h0000FFFF);
    pins[9] = 1'b0; tick();
    pins[9] = 1'b1; tick();
    chk_rd(ra('h40, 1), 32'h02, "R7 status set");
    chk_irq(1'b0, "R7 disabled pin");
    wr(ra('h50, 1), 32'h02);
    chk_irq(1'b1, "R7 enabled pin");
    wr(ra('h50, 1), 32'h00);
    chk_irq(1'b0, "R7 masked again");
    chk_rd(ra('h40, 1), 32'h02, "R7 status kept");
    wr(ra('h70, 1), 32'h02);
    chk_rd(ra('h40, 1), 32'h00, "R6 clear bit");
    wr(ra('h60, 3), 32'h0000FFFF);
    pins[31] = 1'b0; tick();
    pins[31] = 1'b1; tick();
    wr(ra('h50, 3), 32'h80);
    chk_irq(1'b1, "R7 pin 31");
    wr(ra('h70, 3), 32'h80);
    chk_irq(1'b0, "R7 pin 31 cleared");
    wr(ra('h50, 3), 32'h00);

    // R6: zero bits ignored, edge beats clear
    wr(ra('h60, 0), 32'h0000FFFF);
    pins[7:0] = 8'h00; tick();
    pins[7:0] = 8'hFF; tick();
    chk_rd(ra('h40, 0), 32'hFF, "R6 all set");
    wr(ra('h70, 0), 32'h0F);
    chk_rd(ra('h40, 0), 32'hF0, "R6 partial clear");
    pins[0] = 1'b0; tick();
    pins[0] = 1'b1;
    wr(ra('h70, 0), 32'hF1);
    chk_rd(ra('h40, 0), 32'h01, "R6 edge during clear");

    // R8: masked enable and type
    wr(ra('hD0, 2), {16'h0, 8'h0F, 8'h05});
    chk_rd(ra('h50, 2), 32'h05, "R8 masked enable 1");
    wr(ra('hD0, 2), {16'h0, 8'h03, 8'h02});
    chk_rd(ra('h50, 2), 32'h06, "R8 masked enable 2");
    wr(ra('hE0, 2), {8'h10, 24'hFFFFFF});
    chk_rd(ra('h60, 2), 32'h00101010, "R8 masked type");
    wr(ra('h50, 2), 32'h0);

    // R9: masked status
    wr(ra('hC0, 3), {16'h0, 8'h81, 8'h01});
    chk_rd(ra('h40, 3), 32'h01, "R9 masked set");
    wr(ra('hC0, 3), {16'h0, 8'h01, 8'h00});
    chk_rd(ra('h40, 3), 32'h00, "R9 masked clear");

    // R10: type change drops stale history
    pins[8] = 1'b0; tick();
    pins[8] = 1'b1;
    wr(ra('h60, 1), 32'h00FFFF00);
    chk_rd(ra('h40, 1), 32'h00, "R10 write cycle");
    tick();
    pins[8] = 1'b0; tick();
    chk_rd(ra('h40, 1), 32'h01, "R10 new type active");
    wr(ra('h70, 1), 32'h01);
    wr(ra('h60, 1), 32'h00FFFF00);
    pins[8] = 1'b1; tick();
    chk_rd(ra('h40, 1), 32'h00, "R10 cycle after write");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule